// File: doc/BRIEF.md
# Counter overflow flag register

This block keeps one sticky overflow flag for each counter in a performance-counter bank. The bank has one cycle counter, up to 31 event counters and an optional instruction counter. The counters live outside the block. Each counter reports two things: a carry out of its bit 31 and a carry out of its bit 63. Long-mode controls choose which of the two carries counts as an overflow. The cycle counter has its own control. Event counters are split into a lower range and an upper range at a programmable index, and each range has its own control.

Software reaches the flags at two addresses that share one state. A write to the set view raises every flag whose data bit is 1. A write to the clear view lowers every flag whose data bit is 1. A 0 bit has no effect in either view. A read of either view returns the current flags.

The flag vector is also driven out continuously, so that neighbouring logic, such as an interrupt combiner, can use it. The flag layout is fixed:

| Bits | Owner |
|------|-------|
| 0 to 30 | Event counter with the same index |
| 31 | Cycle counter |
| 32 | Instruction counter |
| 33 to 63 | Reserved |

Top module: `ovf_flag_reg`

## Requirements
- R1: While reset is asserted and after it is released, all flags are 0 and the read data is 0.
- R2: A write to the set view (byte offset 0xCC0) sets every implemented flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value. The new value is visible after the write edge.
- R3: A write to the clear view (byte offset 0xC80) clears every flag whose write-data bit is 1. Flags whose write-data bit is 0 keep their value.
- R4: A read of either view returns the current flags in bit positions 32..0, registered at the read edge, with no difference between the two views.
- R5: Flag bit 31 belongs to the cycle counter. When the cycle long-mode input is 0, it is set by that counter's 32-bit carry. When the input is 1, it is set by the 64-bit carry. The other carry is ignored.
- R6: Event counter m sets flag bit m. If m is below the split index, the lower-range long-mode input picks the 32-bit carry (0) or the 64-bit carry (1). Otherwise the upper-range long-mode input makes that choice.
- R7: When the instruction counter is configured present, flag bit 32 is set by that counter's 64-bit carry and can be written through both views. It ignores the 32-bit carry.
- R8: Reserved bits 63..33 and the flags of event counters at or above NUM_EVT read as 0. Writes and carries on those bits are ignored.
- R9: If a counter overflow and a clear-view write of the same flag occur in the same cycle, the flag ends up set.
- R10: An access to any other offset changes no flag, and a read there returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cyc_long | input | 1 | Cycle counter overflows on 64-bit carry when 1 |
| evt_long_lo | input | 1 | Lower-range event counters use the 64-bit carry when 1 |
| evt_long_hi | input | 1 | Upper-range event counters use the 64-bit carry when 1 |
| evt_split | input | 5 | First event-counter index of the upper range |
| wrap32 | input | 33 | Per-counter carry out of bit 31, in flag bit positions |
| wrap64 | input | 33 | Per-counter carry out of bit 63, in flag bit positions |
| acc_req | input | 1 | Register access strobe |
| acc_we | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Byte offset of the access |
| acc_wdata | input | REG_W (64) | Write data |
| acc_rdata | output | REG_W (64) | Read data, registered |
| flags_o | output | 33 | Current overflow flags |

## Verification
A write or a carry pulse that is sampled at a clock edge changes the flags at that same edge. A read is registered at its own edge, so `acc_rdata` holds the result from that edge until the next read. The bench's driver changes inputs on falling edges. For each read, it pushes the expected word into a queue. The monitor notes that a read was sampled at a rising edge and compares the popped entry with `acc_rdata` at the next falling edge, which is half a cycle after the read edge. In the cases where a carry and a clear-view write coincide, both arrive at the same edge, and a later read confirms the result.

// File: rtl/ovf_pkg.sv
package ovf_pkg;
  localparam int FLAG_W   = 33;
  localparam int CYC_BIT  = 31;
  localparam int ICNT_BIT = 32;
  localparam int MAX_EVT  = 31;
  localparam int SPLIT_W  = 5;

  typedef logic [FLAG_W-1:0] flag_vec_t;

  function automatic flag_vec_t impl_mask(input int num_evt, input bit has_icnt);
    flag_vec_t m;
    m = '0;
    for (int i = 0; i < MAX_EVT; i++) begin
      if (i < num_evt) m[i] = 1'b1;
    end
    m[CYC_BIT]  = 1'b1;
    m[ICNT_BIT] = has_icnt;
    return m;
  endfunction
endpackage

// File: rtl/ovf_wrap_sel.sv
module ovf_wrap_sel
  import ovf_pkg::*;
#(
  parameter int NUM_EVT  = 20,
  parameter bit HAS_ICNT = 1'b1
) (
  input  flag_vec_t          wrap32,
  input  flag_vec_t          wrap64,
  input  logic               cyc_long,
  input  logic               evt_long_lo,
  input  logic               evt_long_hi,
  input  logic [SPLIT_W-1:0] evt_split,
  output flag_vec_t          hit
);
  for (genvar gi = 0; gi < FLAG_W; gi++) begin : g_bit
    if (gi < NUM_EVT && gi < MAX_EVT) begin : g_evt
      logic use_long;
      always_comb begin
        use_long = (SPLIT_W'(gi) < evt_split) ? evt_long_lo : evt_long_hi;
        hit[gi]  = use_long ? wrap64[gi] : wrap32[gi];
      end
    end else if (gi == CYC_BIT) begin : g_cyc
      always_comb hit[gi] = cyc_long ? wrap64[gi] : wrap32[gi];
    end else if (gi == ICNT_BIT && HAS_ICNT) begin : g_icnt
      always_comb hit[gi] = wrap64[gi];
    end else begin : g_none
      always_comb hit[gi] = 1'b0;
    end
  end
endmodule

// File: rtl/ovf_flag_bank.sv
module ovf_flag_bank
  import ovf_pkg::*;
#(
  parameter flag_vec_t IMPL = '1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t hw_hit,
  input  flag_vec_t sw_set,
  input  flag_vec_t sw_clr,
  output flag_vec_t flags_q
);
  flag_vec_t flags_d;
  logic      flags_en;

  always_comb begin
    flags_d  = ((flags_q & ~sw_clr) | sw_set | hw_hit) & IMPL;
    flags_en = |(sw_set | sw_clr | hw_hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end

  // R9: a hardware overflow always lands, even against a clear
  p_hw_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_hit != '0) |=> ((flags_q & $past(hw_hit)) == $past(hw_hit)));

  p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_set & IMPL) != '0) |=> ((flags_q & $past(sw_set & IMPL)) == $past(sw_set & IMPL)));

  p_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_clr & ~hw_hit & ~sw_set) != '0) |=> ((flags_q & $past(sw_clr & ~hw_hit & ~sw_set)) == '0));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((sw_set == '0) && (sw_clr == '0) && (hw_hit == '0)) |=> $stable(flags_q));
endmodule

// File: rtl/ovf_reg_port.sv
module ovf_reg_port
  import ovf_pkg::*;
#(
  parameter int          REG_W   = 64,
  parameter int          ADDR_W  = 12,
  parameter logic [11:0] SET_OFS = 12'hCC0,
  parameter logic [11:0] CLR_OFS = 12'hC80
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              acc_we,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  input  flag_vec_t         flags_q,
  output flag_vec_t         sw_set,
  output flag_vec_t         sw_clr,
  output logic [REG_W-1:0]  acc_rdata
);
  flag_vec_t        wd_flags;
  logic [REG_W-1:0] rd_word;
  logic [REG_W-1:0] rdata_d;
  logic             hit_set, hit_clr, rd_en;

  if (REG_W >= FLAG_W) begin : g_wide
    assign wd_flags = acc_wdata[FLAG_W-1:0];
    if (REG_W > FLAG_W) begin : g_pad
      assign rd_word = {{(REG_W-FLAG_W){1'b0}}, flags_q};
    end else begin : g_exact
      assign rd_word = flags_q;
    end
  end else begin : g_narrow
    assign wd_flags = {{(FLAG_W-REG_W){1'b0}}, acc_wdata};
    assign rd_word  = flags_q[REG_W-1:0];
  end

  always_comb begin
    hit_set = acc_req && (acc_addr == ADDR_W'(SET_OFS));
    hit_clr = acc_req && (acc_addr == ADDR_W'(CLR_OFS));
    sw_set  = (hit_set && acc_we) ? wd_flags : '0;
    sw_clr  = (hit_clr && acc_we) ? wd_flags : '0;
    rd_en   = acc_req && !acc_we;
    rdata_d = (hit_set || hit_clr) ? rd_word : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     acc_rdata <= '0;
    else if (rd_en) acc_rdata <= rdata_d;
  end

  // R4: both views return the flags as seen at the read edge
  p_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (hit_set || hit_clr)) |=> (acc_rdata == $past(rd_word)));

  // R10: unmapped read yields zero
  p_unmapped_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit_set && !hit_clr) |=> (acc_rdata == '0));
endmodule

// File: rtl/ovf_flag_reg.sv
module ovf_flag_reg
  import ovf_pkg::*;
#(
  parameter int          NUM_EVT  = 20,
  parameter bit          HAS_ICNT = 1'b1,
  parameter bit          WIDE_ACC = 1'b0,
  parameter logic [11:0] SET_OFS  = 12'hCC0,
  parameter logic [11:0] CLR_OFS  = 12'hC80,
  localparam int         REG_W    = (HAS_ICNT || WIDE_ACC) ? 64 : 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cyc_long,
  input  logic               evt_long_lo,
  input  logic               evt_long_hi,
  input  logic [SPLIT_W-1:0] evt_split,
  input  logic [FLAG_W-1:0]  wrap32,
  input  logic [FLAG_W-1:0]  wrap64,
  input  logic               acc_req,
  input  logic               acc_we,
  input  logic [11:0]        acc_addr,
  input  logic [REG_W-1:0]   acc_wdata,
  output logic [REG_W-1:0]   acc_rdata,
  output logic [FLAG_W-1:0]  flags_o
);
  localparam flag_vec_t IMPL = impl_mask(NUM_EVT, HAS_ICNT);

  flag_vec_t hw_hit, sw_set, sw_clr, flags_q;

  ovf_wrap_sel #(.NUM_EVT(NUM_EVT), .HAS_ICNT(HAS_ICNT)) u_sel (
    .wrap32(wrap32), .wrap64(wrap64), .cyc_long(cyc_long),
    .evt_long_lo(evt_long_lo), .evt_long_hi(evt_long_hi),
    .evt_split(evt_split), .hit(hw_hit)
  );

  ovf_reg_port #(.REG_W(REG_W), .ADDR_W(12), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)) u_port (
    .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_we(acc_we),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .flags_q(flags_q),
    .sw_set(sw_set), .sw_clr(sw_clr), .acc_rdata(acc_rdata)
  );

  ovf_flag_bank #(.IMPL(IMPL)) u_bank (
    .clk(clk), .rst_n(rst_n), .hw_hit(hw_hit), .sw_set(sw_set),
    .sw_clr(sw_clr), .flags_q(flags_q)
  );

  assign flags_o = flags_q;

  // R5: cycle counter flag follows the carry picked by its mode
  p_cyc_sel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((cyc_long ? wrap64[CYC_BIT] : wrap32[CYC_BIT]) == 1'b1) |=> flags_o[CYC_BIT]);
endmodule

// File: tb/tb_ovf_flag_reg.sv
module tb_ovf_flag_reg;
  localparam int          NUM_EVT  = 20;
  localparam bit          HAS_ICNT = 1'b1;
  localparam logic [11:0] SET_A    = 12'hCC0;
  localparam logic [11:0] CLR_A    = 12'hC80;
  localparam logic [32:0] IMPL_B   = ((33'd1 << NUM_EVT) - 33'd1) | 33'h0_8000_0000 |
                                     (HAS_ICNT ? 33'h1_0000_0000 : 33'h0);

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cyc_long, evt_long_lo, evt_long_hi;
  logic [4:0]  evt_split;
  logic [32:0] wrap32, wrap64;
  logic        acc_req, acc_we;
  logic [11:0] acc_addr;
  logic [63:0] acc_wdata, acc_rdata;
  logic [32:0] flags_o;

  always #10 clk = ~clk;

  ovf_flag_reg #(.NUM_EVT(NUM_EVT), .HAS_ICNT(HAS_ICNT)) dut (
    .clk(clk), .rst_n(rst_n), .cyc_long(cyc_long), .evt_long_lo(evt_long_lo),
    .evt_long_hi(evt_long_hi), .evt_split(evt_split), .wrap32(wrap32),
    .wrap64(wrap64), .acc_req(acc_req), .acc_we(acc_we), .acc_addr(acc_addr),
    .acc_wdata(acc_wdata), .acc_rdata(acc_rdata), .flags_o(flags_o)
  );

  typedef struct {
    logic [63:0] exp;
    string       tag;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          errors = 0;
  logic [32:0] mdl;
  logic        mon_due;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [32:0] hw_model(input logic [32:0] w32, input logic [32:0] w64);
    logic [32:0] r = '0;
    for (int i = 0; i < NUM_EVT; i++)
      r[i] = (((i < evt_split) ? evt_long_lo : evt_long_hi)) ? w64[i] : w32[i];
    r[31] = cyc_long ? w64[31] : w32[31];
    r[32] = HAS_ICNT & w64[32];
    return r;
  endfunction

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    acc_req = 1'b1; acc_we = 1'b1; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0;
    if (a == SET_A)      mdl = mdl | (d[32:0] & IMPL_B);
    else if (a == CLR_A) mdl = mdl & ~d[32:0];
  endtask

  task automatic rd(input logic [11:0] a, input logic [63:0] exp, input string tag);
    item_t it;
    @(negedge clk);
    acc_req = 1'b1; acc_we = 1'b0; acc_addr = a;
    it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    acc_req = 1'b0;
  endtask

  task automatic pulse(input logic [32:0] w32, input logic [32:0] w64);
    @(negedge clk);
    wrap32 = w32; wrap64 = w64;
    mdl = mdl | hw_model(w32, w64);
    @(negedge clk);
    wrap32 = '0; wrap64 = '0;
  endtask

  // R9 stimulus: clear-view write and carries in the same cycle
  task automatic clr_with_wrap(input logic [63:0] d, input logic [32:0] w32, input logic [32:0] w64);
    @(negedge clk);
    acc_req = 1'b1; acc_we = 1'b1; acc_addr = CLR_A; acc_wdata = d;
    wrap32 = w32; wrap64 = w64;
    mdl = (mdl & ~d[32:0]) | hw_model(w32, w64);
    @(negedge clk);
    acc_req = 1'b0; acc_we = 1'b0; wrap32 = '0; wrap64 = '0;
  endtask

  always @(posedge clk) mon_due <= rst_n && acc_req && !acc_we;

  always @(negedge clk) begin
    if (mon_due) begin
      if (sbq.size() == 0) begin
        chk("scoreboard underflow", acc_rdata, 64'hX);
      end else begin
        item_t it;
        it = sbq.pop_front();
        chk(it.tag, acc_rdata, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cyc_long = 1'b0; evt_long_lo = 1'b0; evt_long_hi = 1'b0;
    evt_split = 5'd10; wrap32 = '0; wrap64 = '0;
    acc_req = 1'b0; acc_we = 1'b0; acc_addr = '0; acc_wdata = '0;
    mdl = '0;
    repeat (3) @(negedge clk);
    chk("R1 flags in reset", {31'b0, flags_o}, 64'h0);
    chk("R1 rdata in reset", acc_rdata, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags after reset", {31'b0, flags_o}, 64'h0);
    rd(SET_A, 64'h0, "R1 read after reset");

    // R2 set view, R4 read through clear view
    wr(SET_A, 64'h0000_0000_8000_0005);
    rd(CLR_A, {31'b0, mdl}, "R2 R4 set then read clear view");
    wr(SET_A, 64'h0);
    rd(SET_A, {31'b0, mdl}, "R2 zero write keeps flags");

    // R3 clear view
    wr(CLR_A, 64'h1);
    rd(SET_A, {31'b0, mdl}, "R3 clear bit 0");
    wr(CLR_A, 64'h0);
    rd(CLR_A, {31'b0, mdl}, "R3 zero write keeps flags");

    // R8 reserved and unimplemented bits
    wr(SET_A, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(SET_A, {31'b0, IMPL_B}, "R8 only implemented flags set");
    wr(CLR_A, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(SET_A, 64'h0, "R3 clear all");

    // R5 cycle counter width
    cyc_long = 1'b0;
    pulse(33'h0, 33'h0_8000_0000);
    rd(SET_A, 64'h0, "R5 short mode ignores 64-bit carry");
    pulse(33'h0_8000_0000, 33'h0);
    rd(SET_A, 64'h8000_0000, "R5 short mode 32-bit carry");
    wr(CLR_A, 64'h8000_0000);
    cyc_long = 1'b1;
    pulse(33'h0_8000_0000, 33'h0);
    rd(SET_A, 64'h0, "R5 long mode ignores 32-bit carry");
    pulse(33'h0, 33'h0_8000_0000);
    rd(SET_A, 64'h8000_0000, "R5 long mode 64-bit carry");
    wr(CLR_A, 64'hFFFF_FFFF_FFFF_FFFF);

    // R6 event ranges split at 10, R8 counter 25 absent
    evt_long_lo = 1'b1; evt_long_hi = 1'b0;
    pulse(33'h0200_8008, 33'h0201_0010);
    rd(SET_A, 64'h0000_8010, "R6 R8 range selection");
    chk("R6 model", {31'b0, mdl}, 64'h0000_8010);
    evt_split = 5'd4;
    pulse(33'h0000_0020, 33'h0000_0000);
    rd(SET_A, 64'h0000_8030, "R6 moved split");
    wr(CLR_A, 64'hFFFF_FFFF_FFFF_FFFF);

    // R7 instruction counter
    pulse(33'h1_0000_0000, 33'h0);
    rd(SET_A, 64'h0, "R7 ignores 32-bit carry");
    pulse(33'h0, 33'h1_0000_0000);
    rd(CLR_A, 64'h1_0000_0000, "R7 64-bit carry");
    wr(CLR_A, 64'h1_0000_0000);
    rd(SET_A, 64'h0, "R7 clear bit 32");

    // R9 overflow beats same-cycle clear
    evt_split = 5'd10;
    wr(SET_A, 64'h0000_0060);
    clr_with_wrap(64'h0000_0060, 33'h0, 33'h0000_0020);
    rd(SET_A, 64'h0000_0020, "R9 overflow wins over clear");

    // R10 unmapped offset
    wr(12'hC00, 64'hFFFF_FFFF_FFFF_FFFF);
    rd(SET_A, {31'b0, mdl}, "R10 unmapped write ignored");
    rd(12'hC00, 64'h0, "R10 unmapped read zero");

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 64'(sbq.size()), 64'h0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule